// File: doc/BRIEF.md
# Linked-Descriptor DMA Engine

This engine moves data words between a card-side data FIFO and memory buffers. It does not use a fixed register set for each transfer. Software builds a list of four-word descriptors in memory, programs the address of the first one and pulses `go`. The engine fetches each descriptor, checks that software has handed it over, and moves the buffer that the descriptor names. It then writes the control word back with the hand-over flag cleared and moves to the next descriptor. The descriptor's own flags decide where the next descriptor is, where the transfer ends, and which completions raise an interrupt.

The direction is latched when `go` starts the engine from idle. In receive direction (`dir_tx` = 0), words from the FIFO stream are written to memory. In transmit direction (`dir_tx` = 1), buffer words are read from memory and sent on the outgoing stream, which carries begin and end markers. If the engine finds a descriptor it does not own, it parks and raises a status flag until software pulses `go` again. A soft reset aborts any activity, holds the engine for a fixed number of cycles and then clears itself.

Top module: `cdma_chain_engine`

## Requirements
- R1: After reset `busy`, `rst_busy`, `mem_req`, `rx_ready`, `tx_valid`, both interrupt pulses and both status flags are low.
- R2: A `go` from idle fetches the descriptor at `cfg_base` as four read requests to byte addresses base, base+4, base+8 and base+12, in that order.
- R3: If bit 31 (owner) of control word 0 is clear, the engine moves no data, sets `desc_unavail` and keeps `busy` high. A later `go` clears `desc_unavail` and fetches again from the same descriptor address.
- R4: In receive direction, stream words are written to consecutive word addresses starting at the buffer address in word 2. The descriptor takes ceil(size/4) words, where size is bits 12:0 of word 1. No other buffer word is written.
- R5: In transmit direction, ceil(size/4) buffer words are read in address order and sent on `tx_data`. `tx_first` marks the first word of a descriptor with bit 3 (first) set. `tx_last` marks the final word of a descriptor with bit 2 (last) set.
- R6: When a descriptor completes, its word 0 is written back to the descriptor address with bit 31 cleared and all other bits kept. Bit 30 is set if a memory error was flagged on that descriptor's data accesses.
- R7: After a descriptor that is not the last, the next address is word 3 when bit 4 (chain) is set. Otherwise it is the current address plus 16, or `cfg_base` when bit 5 (end of ring) is set.
- R8: After writing back a descriptor with bit 2 set, the engine returns to idle and `busy` falls.
- R9: A write-back raises a one-cycle pulse on the next cycle when bit 2 is set or bit 1 (interrupt suppress) is clear. The pulse is on `rx_irq` in receive direction and on `tx_irq` in transmit direction.
- R10: A descriptor with size zero makes no data access: four reads and one write-back only.
- R11: A `soft_rst` pulse aborts any state and holds `rst_busy` high for exactly RST_CYCLES cycles. The engine then returns to idle with both status flags cleared.
- R12: A memory request holds its address, direction and write data until `mem_gnt`. An outgoing stream word holds its data until `tx_ready`.
- R13: A memory error on any access sets `bus_err`, which stays set until the next accepted `go` or soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Byte address of the first descriptor |
| go | input | 1 | Start pulse from idle, resume pulse from suspend |
| dir_tx | input | 1 | Direction latched at start: 0 receive, 1 transmit |
| soft_rst | input | 1 | Abort-and-reset pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data returned (at least one cycle after grant) |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Error, valid with `mem_rvalid` for reads or `mem_gnt` for writes |
| rx_valid | input | 1 | Incoming FIFO word valid |
| rx_data | input | 32 | Incoming FIFO word |
| rx_ready | output | 1 | Engine accepts an incoming word |
| tx_valid | output | 1 | Outgoing word valid |
| tx_data | output | 32 | Outgoing word |
| tx_first | output | 1 | Outgoing word opens a frame |
| tx_last | output | 1 | Outgoing word closes a frame |
| tx_ready | input | 1 | Sink accepts the outgoing word |
| busy | output | 1 | Engine is walking a list (including suspend) |
| rst_busy | output | 1 | Soft reset in progress |
| rx_irq | output | 1 | Receive completion pulse |
| tx_irq | output | 1 | Transmit completion pulse |
| desc_unavail | output | 1 | Suspended on a descriptor not owned by the engine |
| bus_err | output | 1 | Sticky memory error flag |

## Verification
A stale or wrong descriptor address shows up within a few cycles in the request stream. It fetches the wrong words, writes back over the wrong location, or parks with `desc_unavail` on a descriptor that software released. A miscounted byte span shows up one word early or late, as a buffer word written outside its range or a misplaced `tx_last`. A lost error or ownership flag appears only in the written-back control word, so each scenario reads that word from memory after the engine stops. Suppression mistakes show up as a wrong count of interrupt pulses over a whole list.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

   // control word bit positions (software builds descriptors with these)
   localparam int unsigned CW_OWNER = 31;
   localparam int unsigned CW_ERRSUM = 30;
   localparam int unsigned CW_RINGEND = 5;
   localparam int unsigned CW_LINKED = 4;
   localparam int unsigned CW_OPEN = 3;
   localparam int unsigned CW_CLOSE = 2;
   localparam int unsigned CW_QUIET = 1;

   localparam int unsigned DESC_WORDS = 4;
   localparam int unsigned DESC_STRIDE = DESC_WORDS * 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SRST,
      ST_FREQ,
      ST_FWAIT,
      ST_CHECK,
      ST_RXGET,
      ST_RXWR,
      ST_TXRD,
      ST_TXWAIT,
      ST_TXPUT,
      ST_WB,
      ST_SUSP
   } cdma_state_e;

endpackage

// File: rtl/cdma_desc_store.sv
module cdma_desc_store
   import cdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int SZW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [1:0]    ld_idx,
   input  logic [31:0]   ld_data,
   input  logic          err_mark,
   output logic          own,
   output logic          linked,
   output logic          open_f,
   output logic          close_f,
   output logic          quiet,
   output logic          ringend,
   output logic [SZW-1:0] size,
   output logic [AW-1:0] buf_addr,
   output logic [AW-1:0] next_addr,
   output logic [31:0]   wb_word
);

   logic [31:0] words_q [DESC_WORDS];
   logic        err_q;

   for (genvar gi = 0; gi < int'(DESC_WORDS); gi++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) words_q[gi] <= '0;
         else if (ld_en && ld_idx == 2'(gi)) words_q[gi] <= ld_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else if (ld_en && ld_idx == 2'd0) err_q <= 1'b0;
      else if (err_mark) err_q <= 1'b1;
   end

   assign own = words_q[0][CW_OWNER];
   assign linked = words_q[0][CW_LINKED];
   assign open_f = words_q[0][CW_OPEN];
   assign close_f = words_q[0][CW_CLOSE];
   assign quiet = words_q[0][CW_QUIET];
   assign ringend = words_q[0][CW_RINGEND];
   assign size = words_q[1][SZW-1:0];
   assign buf_addr = words_q[2][AW-1:0];
   assign next_addr = words_q[3][AW-1:0];

   always_comb begin
      wb_word = words_q[0];
      wb_word[CW_OWNER] = 1'b0;
      wb_word[CW_ERRSUM] = words_q[0][CW_ERRSUM] | err_q;
   end

   logic desc_unused;
   if (AW < 32) begin : g_trunc
      assign desc_unused = ^{words_q[1][31:SZW], words_q[2][31:AW], words_q[3][31:AW]};
   end else begin : g_full
      assign desc_unused = ^words_q[1][31:SZW];
   end

   // R6: a recorded error survives until the next descriptor is loaded
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(ld_en && ld_idx == 2'd0)) |=> err_q);

endmodule

// File: rtl/cdma_span_cnt.sv
module cdma_span_cnt #(
   parameter int AW = 32,
   parameter int SZW = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [AW-1:0]  load_addr,
   input  logic [SZW-1:0] load_size,
   input  logic           step,
   output logic [AW-1:0]  cur_addr,
   output logic           rem_zero,
   output logic           final_word,
   output logic           first_word
);

   localparam logic [SZW-1:0] WORD_BYTES = SZW'(4);
   localparam logic [AW-1:0] ADDR_STEP = AW'(4);

   logic [SZW-1:0] rem_q;
   logic [AW-1:0]  addr_q;
   logic           first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         addr_q <= '0;
         first_q <= 1'b0;
      end else if (load) begin
         rem_q <= load_size;
         addr_q <= load_addr;
         first_q <= 1'b1;
      end else if (step) begin
         rem_q <= (rem_q > WORD_BYTES) ? rem_q - WORD_BYTES : '0;
         addr_q <= addr_q + ADDR_STEP;
         first_q <= 1'b0;
      end
   end

   assign cur_addr = addr_q;
   assign rem_zero = (rem_q == '0);
   assign final_word = !rem_zero && (rem_q <= WORD_BYTES);
   assign first_word = first_q;

   // R4: a word is never moved past the end of the buffer span
   a_r4_no_step_past_end: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |-> !rem_zero);

endmodule

// File: rtl/cdma_irq_stat.sv
module cdma_irq_stat (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic go_acc,
   input  logic wb_done,
   input  logic close_f,
   input  logic quiet,
   input  logic dir_tx,
   input  logic unavail_set,
   input  logic err_set,
   output logic rx_irq,
   output logic tx_irq,
   output logic desc_unavail,
   output logic bus_err
);

   logic fire;
   assign fire = wb_done && (close_f || !quiet);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_irq <= 1'b0;
         tx_irq <= 1'b0;
         desc_unavail <= 1'b0;
         bus_err <= 1'b0;
      end else if (clr) begin
         rx_irq <= 1'b0;
         tx_irq <= 1'b0;
         desc_unavail <= 1'b0;
         bus_err <= 1'b0;
      end else begin
         rx_irq <= fire && !dir_tx;
         tx_irq <= fire && dir_tx;
         if (unavail_set) desc_unavail <= 1'b1;
         else if (go_acc) desc_unavail <= 1'b0;
         if (err_set) bus_err <= 1'b1;
         else if (go_acc) bus_err <= 1'b0;
      end
   end

   // R13: the error flag is only dropped by a go or a soft reset
   a_r13_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && !clr && !go_acc) |=> bus_err);

endmodule

// File: rtl/cdma_chain_engine.sv
module cdma_chain_engine
   import cdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int SZW = 13,
   parameter int RST_CYCLES = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cfg_base,
   input  logic          go,
   input  logic          dir_tx,
   input  logic          soft_rst,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_gnt,
   input  logic          mem_rvalid,
   input  logic [31:0]   mem_rdata,
   input  logic          mem_err,
   input  logic          rx_valid,
   input  logic [31:0]   rx_data,
   output logic          rx_ready,
   output logic          tx_valid,
   output logic [31:0]   tx_data,
   output logic          tx_first,
   output logic          tx_last,
   input  logic          tx_ready,
   output logic          busy,
   output logic          rst_busy,
   output logic          rx_irq,
   output logic          tx_irq,
   output logic          desc_unavail,
   output logic          bus_err
);

   localparam int RCW = $clog2(RST_CYCLES + 1);
   localparam logic [RCW-1:0] RST_LOAD = RCW'(RST_CYCLES - 1);
   localparam logic [AW-1:0] STRIDE = AW'(DESC_STRIDE);

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("cdma_chain_engine: AW must lie in 8..32");
   end
   if (SZW < 3 || SZW > 16) begin : g_bad_szw
      $error("cdma_chain_engine: SZW must lie in 3..16");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("cdma_chain_engine: RST_CYCLES must be at least 1");
   end

   cdma_state_e    st_q, st_d;
   logic [1:0]     widx_q, widx_d;
   logic [AW-1:0]  cur_q, cur_d;
   logic [31:0]    dat_q, dat_d;
   logic           dir_q, dir_d;
   logic [RCW-1:0] cnt_q, cnt_d;

   logic           ld_en, span_load, span_step, err_mark, wb_done;
   logic           unavail_set, err_set, go_acc;
   logic           d_own, d_linked, d_open, d_close, d_quiet, d_ringend;
   logic [SZW-1:0] d_size;
   logic [AW-1:0]  d_buf, d_next;
   logic [31:0]    d_wb;
   logic [AW-1:0]  sp_addr;
   logic           sp_zero, sp_final, sp_first;

   cdma_desc_store #(.AW(AW), .SZW(SZW)) desc_i (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(widx_q),
      .ld_data(mem_rdata), .err_mark(err_mark), .own(d_own),
      .linked(d_linked), .open_f(d_open), .close_f(d_close),
      .quiet(d_quiet), .ringend(d_ringend), .size(d_size),
      .buf_addr(d_buf), .next_addr(d_next), .wb_word(d_wb)
   );

   cdma_span_cnt #(.AW(AW), .SZW(SZW)) span_i (
      .clk(clk), .rst_n(rst_n), .load(span_load), .load_addr(d_buf),
      .load_size(d_size), .step(span_step), .cur_addr(sp_addr),
      .rem_zero(sp_zero), .final_word(sp_final), .first_word(sp_first)
   );

   cdma_irq_stat irq_i (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .go_acc(go_acc),
      .wb_done(wb_done), .close_f(d_close), .quiet(d_quiet),
      .dir_tx(dir_q), .unavail_set(unavail_set), .err_set(err_set),
      .rx_irq(rx_irq), .tx_irq(tx_irq), .desc_unavail(desc_unavail),
      .bus_err(bus_err)
   );

   assign go_acc = go && !soft_rst && (st_q == ST_IDLE || st_q == ST_SUSP);

   always_comb begin
      st_d = st_q;
      widx_d = widx_q;
      cur_d = cur_q;
      dat_d = dat_q;
      dir_d = dir_q;
      cnt_d = cnt_q;
      mem_req = 1'b0;
      mem_we = 1'b0;
      mem_addr = '0;
      mem_wdata = '0;
      rx_ready = 1'b0;
      tx_valid = 1'b0;
      tx_first = 1'b0;
      tx_last = 1'b0;
      ld_en = 1'b0;
      span_load = 1'b0;
      span_step = 1'b0;
      err_mark = 1'b0;
      wb_done = 1'b0;
      unavail_set = 1'b0;
      err_set = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (go) begin
               cur_d = cfg_base;
               dir_d = dir_tx;
               widx_d = 2'd0;
               st_d = ST_FREQ;
            end
         end
         ST_SRST: begin
            if (cnt_q == '0) st_d = ST_IDLE;
            else cnt_d = cnt_q - 1'b1;
         end
         ST_FREQ: begin
            mem_req = 1'b1;
            mem_addr = cur_q + AW'({widx_q, 2'b00});
            if (mem_gnt) st_d = ST_FWAIT;
         end
         ST_FWAIT: begin
            if (mem_rvalid) begin
               ld_en = 1'b1;
               err_set = mem_err;
               if (widx_q == 2'd3) begin
                  st_d = ST_CHECK;
               end else begin
                  widx_d = widx_q + 1'b1;
                  st_d = ST_FREQ;
               end
            end
         end
         ST_CHECK: begin
            if (!d_own) begin
               unavail_set = 1'b1;
               st_d = ST_SUSP;
            end else begin
               span_load = 1'b1;
               if (d_size == '0) st_d = ST_WB;
               else if (dir_q) st_d = ST_TXRD;
               else st_d = ST_RXGET;
            end
         end
         ST_RXGET: begin
            rx_ready = 1'b1;
            if (rx_valid) begin
               dat_d = rx_data;
               st_d = ST_RXWR;
            end
         end
         ST_RXWR: begin
            mem_req = 1'b1;
            mem_we = 1'b1;
            mem_addr = sp_addr;
            mem_wdata = dat_q;
            if (mem_gnt) begin
               span_step = 1'b1;
               err_mark = mem_err;
               err_set = mem_err;
               st_d = sp_final ? ST_WB : ST_RXGET;
            end
         end
         ST_TXRD: begin
            mem_req = 1'b1;
            mem_addr = sp_addr;
            if (mem_gnt) st_d = ST_TXWAIT;
         end
         ST_TXWAIT: begin
            if (mem_rvalid) begin
               dat_d = mem_rdata;
               err_mark = mem_err;
               err_set = mem_err;
               st_d = ST_TXPUT;
            end
         end
         ST_TXPUT: begin
            tx_valid = 1'b1;
            tx_first = d_open && sp_first;
            tx_last = d_close && sp_final;
            if (tx_ready) begin
               span_step = 1'b1;
               st_d = sp_final ? ST_WB : ST_TXRD;
            end
         end
         ST_WB: begin
            mem_req = 1'b1;
            mem_we = 1'b1;
            mem_addr = cur_q;
            mem_wdata = d_wb;
            if (mem_gnt) begin
               wb_done = 1'b1;
               err_set = mem_err;
               if (d_close) begin
                  st_d = ST_IDLE;
               end else begin
                  if (d_linked) cur_d = d_next;
                  else if (d_ringend) cur_d = cfg_base;
                  else cur_d = cur_q + STRIDE;
                  widx_d = 2'd0;
                  st_d = ST_FREQ;
               end
            end
         end
         ST_SUSP: begin
            if (go) begin
               widx_d = 2'd0;
               st_d = ST_FREQ;
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (soft_rst) begin
         st_d = ST_SRST;
         cnt_d = RST_LOAD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         widx_q <= '0;
         cur_q <= '0;
         dat_q <= '0;
         dir_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         widx_q <= widx_d;
         cur_q <= cur_d;
         dat_q <= dat_d;
         dir_q <= dir_d;
         cnt_q <= cnt_d;
      end
   end

   assign tx_data = dat_q;
   assign busy = (st_q != ST_IDLE) && (st_q != ST_SRST);
   assign rst_busy = (st_q == ST_SRST);

   // R12: a pending memory request is held unchanged until granted
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   // R12: an offered outgoing word stays until accepted
   a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)
                                   && $stable(tx_first) && $stable(tx_last)));

   // R6: the written-back control word never hands ownership back to the engine
   a_r6_wb_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WB && mem_req) |-> (mem_we && !mem_wdata[CW_OWNER]));

   // R3: an unowned descriptor parks the engine with the status raised
   a_r3_park: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (st_q == ST_CHECK && !d_own) |=> (st_q == ST_SUSP && desc_unavail));

   // R9: a completion pulse only follows a granted write-back
   a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_irq || tx_irq) |-> $past(st_q == ST_WB && mem_gnt && !soft_rst));

   // R11: no memory traffic while the soft reset runs
   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rst_busy |-> (!mem_req && !rx_ready && !tx_valid));

endmodule

// File: tb/cdma_chain_engine_tb_top.sv
`timescale 1ns/1ps
module cdma_chain_engine_tb_top;

   localparam int AW = 32;
   localparam int RSTC = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [AW-1:0] cfg_base = '0;
   logic go = 1'b0, dir_tx = 1'b0, soft_rst = 1'b0;
   logic mem_req, mem_we, mem_gnt, mem_rvalid, mem_err;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic rx_valid, rx_ready, tx_valid, tx_first, tx_last, tx_ready;
   logic [31:0] rx_data, tx_data;
   logic busy, rst_busy, rx_irq, tx_irq, desc_unavail, bus_err;

   cdma_chain_engine #(.AW(AW), .SZW(13), .RST_CYCLES(RSTC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .go(go), .dir_tx(dir_tx),
      .soft_rst(soft_rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .mem_err(mem_err), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
      .tx_ready(tx_ready), .busy(busy), .rst_busy(rst_busy), .rx_irq(rx_irq),
      .tx_irq(tx_irq), .desc_unavail(desc_unavail), .bus_err(bus_err)
   );

   // ---------------- environment models ----------------
   logic [31:0] mem [0:255];
   logic [31:0] cyc = '0;
   logic rv_q = 1'b0, rerr_q = 1'b0;
   logic [31:0] rdat_q = '0;
   logic err_en = 1'b0;
   logic [AW-1:0] err_addr = '0;
   logic rx_en = 1'b0, tx_en = 1'b1;
   logic [31:0] rx_base = '0, rx_idx = '0;
   int acc_n = 0, rx_irq_n = 0, tx_irq_n = 0, tx_n = 0;
   logic [AW-1:0] acc_log [0:63];
   logic [31:0] tx_log [0:15];
   logic [1:0] tx_flg [0:15];

   always @(posedge clk) cyc <= cyc + 1;

   assign mem_gnt = mem_req && (cyc[1:0] != 2'b11);
   assign mem_rvalid = rv_q;
   assign mem_rdata = rdat_q;
   assign mem_err = rv_q ? rerr_q
                         : (mem_gnt && mem_we && err_en && mem_addr == err_addr);
   assign rx_valid = rx_en && !cyc[2];
   assign rx_data = rx_base + rx_idx;
   assign tx_ready = tx_en && !cyc[1];

   always @(posedge clk) begin
      rv_q <= mem_gnt && !mem_we;
      rdat_q <= mem[mem_addr[9:2]];
      rerr_q <= err_en && mem_addr == err_addr;
      if (mem_gnt) begin
         if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
         acc_log[acc_n[5:0]] <= mem_addr;
         acc_n <= acc_n + 1;
      end
      if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
      if (tx_valid && tx_ready) begin
         tx_log[tx_n[3:0]] <= tx_data;
         tx_flg[tx_n[3:0]] <= {tx_first, tx_last};
         tx_n <= tx_n + 1;
      end
      if (rx_irq) rx_irq_n <= rx_irq_n + 1;
      if (tx_irq) tx_irq_n <= tx_irq_n + 1;
   end

   // ---------------- checking helpers ----------------
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
      chk(act === exp, tag, act, exp);
   endtask

   function automatic logic [31:0] rd(input int byte_addr);
      return mem[byte_addr >> 2];
   endfunction

   task automatic put_desc(input int a, input logic [31:0] w0, input logic [31:0] sz,
                           input logic [31:0] bufa, input logic [31:0] nxt);
      mem[a >> 2] = w0;
      mem[(a >> 2) + 1] = sz;
      mem[(a >> 2) + 2] = bufa;
      mem[(a >> 2) + 3] = nxt;
   endtask

   task automatic pulse_go(input int base, input bit dir);
      @(negedge clk);
      cfg_base = AW'(base);
      dir_tx = dir;
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (busy && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(!busy, tag, 32'(busy), 32'h0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk_eq("R1 busy", 32'(busy), 0);
      chk_eq("R1 rst_busy", 32'(rst_busy), 0);
      chk_eq("R1 mem_req", 32'(mem_req), 0);
      chk_eq("R1 stream", 32'({rx_ready, tx_valid}), 0);
      chk_eq("R1 irqs", 32'({rx_irq, tx_irq}), 0);
      chk_eq("R1 status", 32'({desc_unavail, bus_err}), 0);
   endtask

   task automatic t_rx_chain;
      int a0, irq0;
      put_desc(32'h000, 32'h8000_001A, 8, 32'h100, 32'h040);  // owner|link|open|quiet
      put_desc(32'h040, 32'h8000_0004, 6, 32'h180, 32'h0);    // owner|close
      rx_base = 32'hA000;
      rx_idx = 0;
      rx_en = 1'b1;
      a0 = acc_n;
      irq0 = rx_irq_n;
      pulse_go(32'h000, 1'b0);
      wait_idle("R8 rx chain stops after last");
      @(negedge clk);
      chk_eq("R2 fetch addr0", acc_log[a0[5:0]], 32'h000);
      chk_eq("R2 fetch addr1", acc_log[6'(a0 + 1)], 32'h004);
      chk_eq("R2 fetch addr3", acc_log[6'(a0 + 3)], 32'h00C);
      chk_eq("R4 buf0 w0", rd(32'h100), 32'hA000);
      chk_eq("R4 buf0 w1", rd(32'h104), 32'hA001);
      chk_eq("R4 buf0 untouched", rd(32'h108), 32'hDEAD_0042);
      chk_eq("R7 linked next buf w0", rd(32'h180), 32'hA002);
      chk_eq("R4 round-up word", rd(32'h184), 32'hA003);
      chk_eq("R4 past span untouched", rd(32'h188), 32'hDEAD_0062);
      chk_eq("R6 wb first", rd(32'h000), 32'h0000_001A);
      chk_eq("R6 wb last", rd(32'h040), 32'h0000_0004);
      chk_eq("R9 rx irq count", 32'(rx_irq_n - irq0), 1);
      chk_eq("R2 access count", 32'(acc_n - a0), 14);
      rx_en = 1'b0;
   endtask

   task automatic t_tx;
      int t0, irq0, rirq0;
      put_desc(32'h080, 32'h8000_000C, 12, 32'h200, 32'h0);   // owner|open|close
      mem[32'h200 >> 2] = 32'h11;
      mem[32'h204 >> 2] = 32'h22;
      mem[32'h208 >> 2] = 32'h33;
      t0 = tx_n;
      irq0 = tx_irq_n;
      rirq0 = rx_irq_n;
      pulse_go(32'h080, 1'b1);
      wait_idle("R8 tx stops");
      @(negedge clk);
      chk_eq("R5 tx word count", 32'(tx_n - t0), 3);
      chk_eq("R5 tx w0", tx_log[t0[3:0]], 32'h11);
      chk_eq("R5 tx w2", tx_log[4'(t0 + 2)], 32'h33);
      chk_eq("R5 flags w0", 32'(tx_flg[t0[3:0]]), 32'h2);
      chk_eq("R5 flags w1", 32'(tx_flg[4'(t0 + 1)]), 32'h0);
      chk_eq("R5 flags w2", 32'(tx_flg[4'(t0 + 2)]), 32'h1);
      chk_eq("R9 tx irq", 32'(tx_irq_n - irq0), 1);
      chk_eq("R9 no rx irq in tx", 32'(rx_irq_n - rirq0), 0);
      chk_eq("R6 tx wb", rd(32'h080), 32'h0000_000C);
   endtask

   task automatic t_ring_suspend;
      int irq0, n;
      put_desc(32'h0C0, 32'h8000_0000, 4, 32'h280, 32'h0);    // owner, sequential
      put_desc(32'h0D0, 32'h8000_0020, 4, 32'h284, 32'h0);    // owner|ring end
      rx_base = 32'hB000;
      rx_idx = 0;
      rx_en = 1'b1;
      irq0 = rx_irq_n;
      pulse_go(32'h0C0, 1'b0);
      n = 0;
      while (!desc_unavail && n < 3000) begin
         @(negedge clk);
         n++;
      end
      repeat (4) @(negedge clk);
      chk_eq("R3 unavail raised", 32'(desc_unavail), 1);
      chk_eq("R3 busy while parked", 32'(busy), 1);
      chk_eq("R7 sequential next", rd(32'h284), 32'hB001);
      chk_eq("R7 first buf", rd(32'h280), 32'hB000);
      chk_eq("R7 ring end wb", rd(32'h0D0), 32'h0000_0020);
      chk_eq("R3 no data when unowned", rd(32'h288), 32'hDEAD_00A2);
      chk_eq("R9 unsuppressed irqs", 32'(rx_irq_n - irq0), 2);
      put_desc(32'h0C0, 32'h8000_0004, 4, 32'h288, 32'h0);
      pulse_go(32'h000, 1'b0);                                 // base ignored on resume
      wait_idle("R3 resume completes");
      @(negedge clk);
      chk_eq("R3 resumed same desc", rd(32'h288), 32'hB002);
      chk_eq("R3 unavail cleared", 32'(desc_unavail), 0);
      rx_en = 1'b0;
   endtask

   task automatic t_zero_size;
      int a0, irq0;
      put_desc(32'h300, 32'h8000_0004, 0, 32'h380, 32'h0);
      a0 = acc_n;
      irq0 = rx_irq_n;
      pulse_go(32'h300, 1'b0);
      wait_idle("R10 zero size stops");
      @(negedge clk);
      chk_eq("R10 access count", 32'(acc_n - a0), 5);
      chk_eq("R10 buffer untouched", rd(32'h380), 32'hDEAD_00E0);
      chk_eq("R10 irq", 32'(rx_irq_n - irq0), 1);
   endtask

   task automatic t_bus_err;
      put_desc(32'h340, 32'h8000_0004, 8, 32'h390, 32'h0);
      rx_base = 32'hC000;
      rx_idx = 0;
      rx_en = 1'b1;
      err_en = 1'b1;
      err_addr = 32'h394;
      pulse_go(32'h340, 1'b0);
      wait_idle("R13 err run stops");
      @(negedge clk);
      chk_eq("R13 bus_err set", 32'(bus_err), 1);
      chk_eq("R6 error summary wb", rd(32'h340), 32'h4000_0004);
      chk_eq("R4 data with error", rd(32'h390), 32'hC000);
      err_en = 1'b0;
      rx_en = 1'b0;
      repeat (5) @(negedge clk);
      chk_eq("R13 bus_err sticky", 32'(bus_err), 1);
   endtask

   task automatic t_soft_reset;
      int n;
      put_desc(32'h3C0, 32'h8000_0004, 8, 32'h3A0, 32'h0);
      rx_en = 1'b0;
      pulse_go(32'h3C0, 1'b0);
      repeat (30) @(negedge clk);
      chk_eq("R11 hung before reset", 32'({busy, rx_ready}), 32'h3);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      n = 0;
      for (int k = 0; k < 40; k++) begin
         if (rst_busy) n++;
         @(negedge clk);
      end
      chk_eq("R11 reset length", 32'(n), RSTC);
      chk_eq("R11 idle after", 32'({busy, rst_busy, rx_ready}), 0);
      put_desc(32'h3E0, 32'h0000_0004, 4, 32'h3F0, 32'h0);   // not owned
      pulse_go(32'h3E0, 1'b0);
      repeat (40) @(negedge clk);
      chk_eq("R3 parks on unowned", 32'(desc_unavail), 1);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      repeat (RSTC + 2) @(negedge clk);
      chk_eq("R11 status cleared", 32'({desc_unavail, bus_err, busy}), 0);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_chain();
      t_tx();
      t_ring_suspend();
      t_zero_size();
      t_bus_err();
      t_soft_reset();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

endmodule